// File: doc/BRIEF.md
# DMA Channel Status and Chain Address Registers

This block is the register front end of one DMA channel. It holds two 64-bit values behind a 32-bit register bus: a live status word and a chain start address. The status word reports the address of the last descriptor the channel finished and the channel's transfer state. The descriptor engine updates it through a strobe, and it may do so at any moment, including between two software reads of the two halves.

The bus only moves one 32-bit word per access, so a 64-bit value is read in two halves. A read of the low half of the status word also copies the high half into a holding register. A later read of the high half returns that copy. Both halves then come from one value of the live word.

The chain start address is written by software. It is checked only when the engine pulses the start of the first descriptor fetch. An address with any of its six low bits set, or an address of zero, raises a sticky error output and forces the state to halted. An address that passes the check sets the state to active and clears the error.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the state field is 3'b011 (halted), the completed-descriptor address, the chain address, the high-half holding register and `rdata` are zero, and `chain_addr_err` is 0.
- R2: Register offsets are 0x0 for the status low half, 0x4 for the status high half, 0x8 for the chain address low half and 0xC for the chain address high half. `rdata` changes on the clock edge that samples `rd_en` and holds between reads. Any other offset reads as zero.
- R3: Status word layout: bits [2:0] hold the state, bits 5:3 always read 0, and bits [63:6] hold bits [63:6] of the last completed descriptor address.
- R4: A read of offset 0x0 captures bits [63:32] of the status word in the same cycle. A later read of offset 0x4 returns the captured value even if the live word has changed since.
- R5: A read of offset 0x4 with no low-half read before it returns the most recent captured value, and that value does not change until the next low-half read.
- R6: When a status update comes in the same cycle as a low-half read, the returned low half and the captured high half both hold the value from before the update. The update shows on the next read.
- R7: The chain address can be read and written in 32-bit halves at 0x8 and 0xC. Writes to any other offset change nothing.
- R8: On `fetch_start`, if the chain address is zero or any of bits [5:0] is set, `chain_addr_err` is set to 1 and the state becomes 3'b011 on the next cycle.
- R9: Writing an invalid chain address does not affect `chain_addr_err`. A `fetch_start` with a valid address clears `chain_addr_err` and sets the state to 3'b000 (active).
- R10: `chain_addr_err` changes only on `fetch_start`. A `fetch_start` decides the state even when a status update comes in the same cycle.
- R11: `upd_valid` loads the completed-descriptor address and `upd_state` into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| fetch_start | input | 1 | Pulse at the start of the first descriptor fetch |
| upd_valid | input | 1 | Engine status update strobe |
| upd_desc_addr | input | 64 | Address of the descriptor just completed |
| upd_state | input | 3 | New transfer state |
| chain_addr | output | 64 | Chain start address for the fetch engine |
| chain_addr_err | output | 1 | Sticky chain address validation error |

## Verification
Two things can happen in the same cycle. A software read of the status low half can meet an engine status update, and a chain-address check at fetch start can meet a state update. The bench drives the update strobe on the exact cycle of the low-half read. It then expects the old low half in `rdata` and the old high half on the next high-half read, and the new value only on a later low-half read. It also pulses `fetch_start` together with `upd_valid` and expects the state from the fetch, not the one carried by the update.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W     = 4,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              fetch_start,
  input  logic              upd_valid,
  input  logic [63:0]       upd_desc_addr,
  input  logic [2:0]        upd_state,
  output logic [63:0]       chain_addr,
  output logic              chain_addr_err
);

  localparam int DESC_W = 64 - ALIGN_BITS;
  localparam logic [ADDR_W-1:0] OFF_ST_LO = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_ST_HI = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_CH_LO = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFF_CH_HI = ADDR_W'(4'hC);
  localparam logic [2:0] ST_ACTIVE = 3'b000;
  localparam logic [2:0] ST_HALTED = 3'b011;

  logic [DESC_W-1:0] done_desc;
  logic [2:0]        xfer_state;
  logic [31:0]       hi_hold;
  logic [63:0]       status_word;
  logic              chain_bad;
  logic              rd_lo;

  assign status_word = {done_desc, {(ALIGN_BITS-3){1'b0}}, xfer_state};
  assign chain_bad   = (chain_addr == '0) || (chain_addr[ALIGN_BITS-1:0] != '0);
  assign rd_lo       = rd_en && (addr == OFF_ST_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata          <= '0;
      hi_hold        <= '0;
      done_desc      <= '0;
      xfer_state     <= ST_HALTED;
      chain_addr     <= '0;
      chain_addr_err <= 1'b0;
    end else begin
      if (rd_en) begin
        case (addr)
          OFF_ST_LO: begin
            rdata   <= status_word[31:0];
            hi_hold <= status_word[63:32];
          end
          OFF_ST_HI: rdata <= hi_hold;
          OFF_CH_LO: rdata <= chain_addr[31:0];
          OFF_CH_HI: rdata <= chain_addr[63:32];
          default:   rdata <= '0;
        endcase
      end
      if (wr_en && addr == OFF_CH_LO) chain_addr[31:0]  <= wdata;
      if (wr_en && addr == OFF_CH_HI) chain_addr[63:32] <= wdata;
      if (upd_valid) done_desc <= upd_desc_addr[63:ALIGN_BITS];
      if (fetch_start) begin
        chain_addr_err <= chain_bad;
        xfer_state     <= chain_bad ? ST_HALTED : ST_ACTIVE;
      end else if (upd_valid) begin
        xfer_state <= upd_state;
      end
    end
  end

  AST_LOW_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hi_hold == $past(status_word[63:32])) && (rdata == $past(status_word[31:0]))); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(hi_hold)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> rdata[5:3] == 3'b000); // R3
  AST_BAD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && chain_bad) |=> chain_addr_err && (xfer_state == ST_HALTED)); // R8
  AST_ERR_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_start |=> $stable(chain_addr_err)); // R10
  AST_GOOD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && !chain_bad) |=> !chain_addr_err && (xfer_state == ST_ACTIVE)); // R9

endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fetch_start = 1'b0, upd_valid = 1'b0;
  logic [63:0] upd_desc_addr = '0;
  logic [2:0]  upd_state = '0;
  logic [63:0] chain_addr;
  logic        chain_addr_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dma_chan_regs dut (.*);

  function automatic logic [63:0] sw(input logic [63:0] a, input logic [2:0] s);
    return {a[63:6], 3'b000, s};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic upd(input logic [63:0] a, input logic [2:0] s);
    @(negedge clk); upd_desc_addr = a; upd_state = s; upd_valid = 1'b1;
    @(negedge clk); upd_valid = 1'b0;
  endtask

  task automatic fetch();
    @(negedge clk); fetch_start = 1'b1;
    @(negedge clk); fetch_start = 1'b0;
  endtask

  task automatic wr_chain(input logic [63:0] a);
    wr(4'h8, a[31:0]); wr(4'hC, a[63:32]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", {32'h0, rdata}, 64'h0);
    rd(4'h0, d); chk("R1 status lo", {32'h0, d}, 64'h3);
    rd(4'h4, d); chk("R1 status hi", {32'h0, d}, 64'h0);
    rd(4'h8, d); chk("R1 chain lo", {32'h0, d}, 64'h0);
    chk("R1 err", {63'h0, chain_addr_err}, 64'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h4, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R7 status write ignored", {32'h0, d}, 64'h3);
    chk("R7 chain untouched", chain_addr, 64'h0);
    rd(4'h1, d); chk("R2 unmapped reads zero", {32'h0, d}, 64'h0);
  endtask

  task automatic t_update();
    logic [31:0] lo, hi;
    logic [63:0] a = 64'h1234_5678_9ABC_DEFF;
    upd(a, 3'b001);
    rd(4'h0, lo); rd(4'h4, hi);
    chk("R11 R3 status word", {hi, lo}, sw(a, 3'b001));
  endtask

  task automatic t_latch();
    logic [31:0] d;
    logic [63:0] a = 64'hAAAA_0001_0000_0040;
    logic [63:0] b = 64'h5555_0002_0000_0080;
    upd(a, 3'b000);
    rd(4'h0, d);
    upd(b, 3'b010);
    rd(4'h4, d); chk("R4 hi from latch", {32'h0, d}, {32'h0, a[63:32]});
    rd(4'h0, d); chk("R4 new lo", {32'h0, d}, {32'h0, sw(b, 3'b010) >> 0} & 64'hFFFF_FFFF);
    upd(64'hCCCC_0003_0000_00C0, 3'b001);
    rd(4'h4, d); chk("R5 hi without lo read", {32'h0, d}, {32'h0, b[63:32]});
    rd(4'h4, d); chk("R5 hi repeat", {32'h0, d}, {32'h0, b[63:32]});
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    logic [63:0] p = 64'h0F0F_0F0F_1111_1100;
    logic [63:0] q = 64'hF0F0_F0F0_2222_2200;
    upd(p, 3'b001);
    @(negedge clk); addr = 4'h0; rd_en = 1'b1;
    upd_desc_addr = q; upd_state = 3'b010; upd_valid = 1'b1;
    @(negedge clk); rd_en = 1'b0; upd_valid = 1'b0;
    chk("R6 lo before update", {32'h0, rdata}, sw(p, 3'b001) & 64'hFFFF_FFFF);
    rd(4'h4, d); chk("R6 hi before update", {32'h0, d}, {32'h0, p[63:32]});
    rd(4'h0, d); chk("R6 lo after update", {32'h0, d}, sw(q, 3'b010) & 64'hFFFF_FFFF);
  endtask

  task automatic t_chain();
    logic [31:0] lo, hi;
    wr_chain(64'h0000_0012_3456_7841);
    rd(4'h8, lo); rd(4'h C, hi);
    chk("R7 chain readback", {hi, lo}, 64'h0000_0012_3456_7841);
    chk("R7 chain port", chain_addr, 64'h0000_0012_3456_7841);
    chk("R9 no check at write", {63'h0, chain_addr_err}, 64'h0);
    fetch();
    chk("R8 misaligned err", {63'h0, chain_addr_err}, 64'h1);
    rd(4'h0, lo); chk("R8 halted", {61'h0, lo[2:0]}, 64'h3);
    wr_chain(64'h0000_0000_0000_1000);
    fetch();
    chk("R9 err cleared", {63'h0, chain_addr_err}, 64'h0);
    rd(4'h0, lo); chk("R9 active", {61'h0, lo[2:0]}, 64'h0);
    wr_chain(64'h0);
    fetch();
    chk("R8 zero addr err", {63'h0, chain_addr_err}, 64'h1);
    upd(64'h40, 3'b001);
    chk("R10 err holds on update", {63'h0, chain_addr_err}, 64'h1);
    wr_chain(64'h8000_0000_0000_0000);
    @(negedge clk); fetch_start = 1'b1; upd_valid = 1'b1;
    upd_desc_addr = 64'h80; upd_state = 3'b010;
    @(negedge clk); fetch_start = 1'b0; upd_valid = 1'b0;
    chk("R10 err cleared by fetch", {63'h0, chain_addr_err}, 64'h0);
    rd(4'h0, lo); chk("R10 fetch state wins", {32'h0, lo}, 64'h80);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_update();
    t_latch();
    t_same_cycle();
    t_chain();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule